// File: doc/BRIEF.md
# Ring Node Interface Unit

This block attaches one node to a unidirectional ring interconnect. Chained instances form the ring, because each has exactly one ring input link and one ring output link. A composition stage takes local send requests and turns each one into a complete network message. The message is stamped with the node's own identity as source, and it waits in one of two virtual-channel queues. The two channels are high priority and low priority.

A separate transmit/receive stage watches the ring input. Messages addressed to this node are pulled off the ring into per-channel receive queues. Through-traffic is passed straight to the output register. Local messages are injected only into output slots that through-traffic leaves empty. A message that comes back to the node that sent it has reached nobody: it is removed from the ring and a one-cycle flag reports it.

Every message occupies exactly one ring slot. Each ring link carries a valid signal and, per channel, a ready signal, so the two channels are flow-controlled independently.

Top module: `ring_niu`

## Requirements
- R1: A local send request accepted on the send port becomes one message whose layout, from the most significant bit down, is: priority (1 bit, 1 = high), destination (4), source (4), size (4), tag (4), command (3), data (16), which gives 36 bits. The source field is set to the node identity `NODE_ID`, and every other field is carried unchanged.
- R2: Each channel has its own send queue of `QDEPTH` entries. `tx_ready[c]` is low exactly while send queue c is full. A full queue on one channel does not lower the ready of the other channel.
- R3: A ring input message whose destination differs from `NODE_ID` and whose source differs from `NODE_ID` is accepted and appears unchanged on the ring output in the next cycle.
- R4: Through-traffic takes precedence over local injection. While a through message is accepted in every cycle, no local message leaves.
- R5: Local messages are injected only into an output slot that is free. When both send queues hold messages, the high-priority queue is served first. Each message fills exactly one slot.
- R6: While the downstream ready for the channel of the message on the output is low, the output stays valid and holds its message unchanged.
- R7: A ring input message whose destination equals `NODE_ID` is delivered on the receive port in arrival order within its channel. Whenever a high-priority message is waiting, it is presented before any low-priority one.
- R8: While the receive queue of channel c holds `QDEPTH` messages, `rin_ready[c]` is low and ring input on channel c is stalled.
- R9: A ring input message whose source equals `NODE_ID` and whose destination differs from it is dropped. It does not appear on the ring output, and `undeliv` is high for exactly the following cycle.
- R10: After reset the ring output and the receive port are not valid, `undeliv` is low, and both bits of `tx_ready` and `rin_ready` are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid | input | 1 | Local send request present |
| tx_pri | input | 1 | Channel of the request, 1 = high |
| tx_dest | input | 4 | Destination node |
| tx_size | input | 4 | Total message size field |
| tx_tag | input | 4 | Network tag field |
| tx_cmd | input | 3 | Network command field |
| tx_data | input | 16 | Message payload |
| tx_ready | output | 2 | Per-channel send queue has room |
| rin_valid | input | 1 | Ring input message present |
| rin_msg | input | 36 | Ring input message |
| rin_ready | output | 2 | Per-channel ring input accept |
| rout_valid | output | 1 | Ring output message present |
| rout_msg | output | 36 | Ring output message |
| rout_ready | input | 2 | Per-channel downstream accept |
| rx_valid | output | 1 | Received message present |
| rx_msg | output | 36 | Received message, high channel first |
| rx_accept | input | 1 | Local consumer takes the received message |
| undeliv | output | 1 | A self-sourced message returned and was dropped |

## Verification
The hardest situations to reach from the ports are a full receive queue on one channel with the other channel still open, and both send queues filled at the same moment. Random traffic rarely lines up either case. The stimulus therefore holds the downstream ready or the local accept low on purpose. This lets messages pile up behind a stalled output or a stalled consumer, and the design is then released so the ordering and stall rules can be observed. Random cycles that mix through-traffic, self-sourced returns and local sends are checked against per-channel scoreboards kept by the bench.

// File: rtl/rnode_pkg.sv
package rnode_pkg;
  localparam int NODE_W = 4;
  localparam int SIZE_W = 4;
  localparam int TAG_W  = 4;
  localparam int CMD_W  = 3;
  localparam int DATA_W = 16;
  localparam int NUM_VC = 2;
  localparam int VC_LO  = 0;
  localparam int VC_HI  = 1;

  typedef struct packed {
    logic              pri;
    logic [NODE_W-1:0] dest;
    logic [NODE_W-1:0] src;
    logic [SIZE_W-1:0] size;
    logic [TAG_W-1:0]  tag;
    logic [CMD_W-1:0]  cmd;
    logic [DATA_W-1:0] data;
  } ring_msg_t;

  localparam int MSG_W = $bits(ring_msg_t);

  // channel chosen among non-empty queues: high wins
  function automatic logic vc_pick(input logic [NUM_VC-1:0] nonempty);
    return nonempty[VC_HI];
  endfunction

  function automatic ring_msg_t build_msg(
    input logic pri, input logic [NODE_W-1:0] dest, input logic [NODE_W-1:0] src,
    input logic [SIZE_W-1:0] size, input logic [TAG_W-1:0] tag,
    input logic [CMD_W-1:0] cmd, input logic [DATA_W-1:0] data);
    ring_msg_t m;
    m.pri = pri; m.dest = dest; m.src = src; m.size = size;
    m.tag = tag; m.cmd = cmd; m.data = data;
    return m;
  endfunction
endpackage

// File: rtl/rnode_fifo.sv
module rnode_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (count == (AW+1)'(DEPTH));
  assign empty = (count == '0);
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= ptr_next(wr_ptr);
      if (pop)  rd_ptr <= ptr_next(rd_ptr);
      count <= count + (AW+1)'(push) - (AW+1)'(pop);
    end
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push && !pop |-> !full);
  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  // R8
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (AW+1)'(DEPTH));
endmodule

// File: rtl/rnode_compose.sv
module rnode_compose
  import rnode_pkg::*;
#(
  parameter int NODE_ID = 5,
  parameter int QDEPTH  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tx_valid,
  input  logic                     tx_pri,
  input  logic [NODE_W-1:0]        tx_dest,
  input  logic [SIZE_W-1:0]        tx_size,
  input  logic [TAG_W-1:0]         tx_tag,
  input  logic [CMD_W-1:0]         tx_cmd,
  input  logic [DATA_W-1:0]        tx_data,
  output logic [NUM_VC-1:0]        tx_ready,
  input  logic [NUM_VC-1:0]        ins_pop,
  output ring_msg_t [NUM_VC-1:0]   q_head,
  output logic [NUM_VC-1:0]        q_nonempty
);
  localparam logic [NODE_W-1:0] MY_ID = NODE_W'(NODE_ID);

  ring_msg_t composed;
  assign composed = build_msg(tx_pri, tx_dest, MY_ID, tx_size, tx_tag, tx_cmd, tx_data);

  for (genvar c = 0; c < NUM_VC; c++) begin : g_txq
    logic full_c, empty_c, push_c;
    logic [MSG_W-1:0] head_c;
    assign push_c = tx_valid && (tx_pri == 1'(c)) && !full_c;
    rnode_fifo #(.W(MSG_W), .DEPTH(QDEPTH)) u_q (
      .clk(clk), .rst_n(rst_n), .push(push_c), .din(composed),
      .pop(ins_pop[c]), .dout(head_c), .full(full_c), .empty(empty_c));
    assign tx_ready[c]   = !full_c;
    assign q_nonempty[c] = !empty_c;
    assign q_head[c]     = ring_msg_t'(head_c);
  end
endmodule

// File: rtl/rnode_ringio.sv
module rnode_ringio
  import rnode_pkg::*;
#(
  parameter int NODE_ID = 5,
  parameter int QDEPTH  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rin_valid,
  input  ring_msg_t              rin_msg,
  output logic [NUM_VC-1:0]      rin_ready,
  output logic                   rout_valid,
  output ring_msg_t              rout_msg,
  input  logic [NUM_VC-1:0]      rout_ready,
  output logic                   rx_valid,
  output ring_msg_t              rx_msg,
  input  logic                   rx_accept,
  input  ring_msg_t [NUM_VC-1:0] tx_head,
  input  logic [NUM_VC-1:0]      tx_nonempty,
  output logic [NUM_VC-1:0]      ins_pop,
  output logic                   undeliv
);
  localparam logic [NODE_W-1:0] MY_ID = NODE_W'(NODE_ID);

  // named internal events
  logic out_free, rin_take, ext_take, drop_take, fwd_take, ins_take, ins_vc;
  logic rx_sel;
  logic [NUM_VC-1:0] rx_full, rx_ne, rx_pop;
  ring_msg_t [NUM_VC-1:0] rx_head;

  assign out_free  = !rout_valid || rout_ready[rout_msg.pri];
  for (genvar c = 0; c < NUM_VC; c++) begin : g_rdy
    assign rin_ready[c] = out_free && !rx_full[c];
  end
  assign rin_take  = rin_valid && rin_ready[rin_msg.pri];
  assign ext_take  = rin_take && (rin_msg.dest == MY_ID);
  assign drop_take = rin_take && (rin_msg.dest != MY_ID) && (rin_msg.src == MY_ID);
  assign fwd_take  = rin_take && (rin_msg.dest != MY_ID) && (rin_msg.src != MY_ID);

  assign ins_vc   = vc_pick(tx_nonempty);
  assign ins_take = out_free && !fwd_take && (|tx_nonempty);
  for (genvar c = 0; c < NUM_VC; c++) begin : g_ins
    assign ins_pop[c] = ins_take && (ins_vc == 1'(c));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rout_valid <= 1'b0;
      rout_msg   <= '0;
      undeliv    <= 1'b0;
    end else begin
      undeliv <= drop_take;
      if (fwd_take) begin
        rout_valid <= 1'b1;
        rout_msg   <= rin_msg;
      end else if (ins_take) begin
        rout_valid <= 1'b1;
        rout_msg   <= tx_head[ins_vc];
      end else if (out_free) begin
        rout_valid <= 1'b0;
      end
    end
  end

  for (genvar c = 0; c < NUM_VC; c++) begin : g_rxq
    logic push_c, empty_c;
    logic [MSG_W-1:0] head_c;
    assign push_c = ext_take && (rin_msg.pri == 1'(c));
    rnode_fifo #(.W(MSG_W), .DEPTH(QDEPTH)) u_q (
      .clk(clk), .rst_n(rst_n), .push(push_c), .din(rin_msg),
      .pop(rx_pop[c]), .dout(head_c), .full(rx_full[c]), .empty(empty_c));
    assign rx_ne[c]   = !empty_c;
    assign rx_head[c] = ring_msg_t'(head_c);
    assign rx_pop[c]  = rx_accept && rx_valid && (rx_sel == 1'(c));
  end

  assign rx_sel   = vc_pick(rx_ne);
  assign rx_valid = |rx_ne;
  assign rx_msg   = rx_head[rx_sel];

  // R3
  fwd_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_take |=> rout_valid && rout_msg == $past(rin_msg));
  // R4
  fwd_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_take && (|tx_nonempty) |=> rout_msg.src != MY_ID);
  // R5
  hi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_take && tx_nonempty[VC_HI] |=> rout_valid && rout_msg.pri);
  // R6
  rout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rout_valid && !rout_ready[rout_msg.pri] |=> rout_valid && $stable(rout_msg));
  // R8
  rx_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rin_valid && rx_full[rin_msg.pri] |-> !ext_take);
  // R9
  drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_take |=> undeliv && !(rout_valid && rout_msg == $past(rin_msg)));
endmodule

// File: rtl/ring_niu.sv
module ring_niu
  import rnode_pkg::*;
#(
  parameter int NODE_ID = 5,
  parameter int QDEPTH  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tx_valid,
  input  logic                tx_pri,
  input  logic [NODE_W-1:0]   tx_dest,
  input  logic [SIZE_W-1:0]   tx_size,
  input  logic [TAG_W-1:0]    tx_tag,
  input  logic [CMD_W-1:0]    tx_cmd,
  input  logic [DATA_W-1:0]   tx_data,
  output logic [NUM_VC-1:0]   tx_ready,
  input  logic                rin_valid,
  input  logic [MSG_W-1:0]    rin_msg,
  output logic [NUM_VC-1:0]   rin_ready,
  output logic                rout_valid,
  output logic [MSG_W-1:0]    rout_msg,
  input  logic [NUM_VC-1:0]   rout_ready,
  output logic                rx_valid,
  output logic [MSG_W-1:0]    rx_msg,
  input  logic                rx_accept,
  output logic                undeliv
);
  ring_msg_t [NUM_VC-1:0] tx_head;
  logic [NUM_VC-1:0]      tx_nonempty, ins_pop;
  ring_msg_t              rout_s, rx_s;

  rnode_compose #(.NODE_ID(NODE_ID), .QDEPTH(QDEPTH)) u_compose (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_pri(tx_pri),
    .tx_dest(tx_dest), .tx_size(tx_size), .tx_tag(tx_tag), .tx_cmd(tx_cmd),
    .tx_data(tx_data), .tx_ready(tx_ready), .ins_pop(ins_pop),
    .q_head(tx_head), .q_nonempty(tx_nonempty));

  rnode_ringio #(.NODE_ID(NODE_ID), .QDEPTH(QDEPTH)) u_ringio (
    .clk(clk), .rst_n(rst_n), .rin_valid(rin_valid), .rin_msg(ring_msg_t'(rin_msg)),
    .rin_ready(rin_ready), .rout_valid(rout_valid), .rout_msg(rout_s),
    .rout_ready(rout_ready), .rx_valid(rx_valid), .rx_msg(rx_s),
    .rx_accept(rx_accept), .tx_head(tx_head), .tx_nonempty(tx_nonempty),
    .ins_pop(ins_pop), .undeliv(undeliv));

  assign rout_msg = rout_s;
  assign rx_msg   = rx_s;
endmodule

// File: tb/ring_niu_test.sv
module ring_niu_test;
  localparam int ID = 5;
  localparam int QD = 4;
  localparam int MW = 36;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic tx_valid, tx_pri;
  logic [3:0] tx_dest, tx_size, tx_tag;
  logic [2:0] tx_cmd;
  logic [15:0] tx_data;
  logic [1:0] tx_ready, rin_ready, rout_ready;
  logic rin_valid, rout_valid, rx_valid, rx_accept, undeliv;
  logic [MW-1:0] rin_msg, rout_msg, rx_msg;

  ring_niu uut (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_pri(tx_pri),
    .tx_dest(tx_dest), .tx_size(tx_size), .tx_tag(tx_tag), .tx_cmd(tx_cmd),
    .tx_data(tx_data), .tx_ready(tx_ready), .rin_valid(rin_valid),
    .rin_msg(rin_msg), .rin_ready(rin_ready), .rout_valid(rout_valid),
    .rout_msg(rout_msg), .rout_ready(rout_ready), .rx_valid(rx_valid),
    .rx_msg(rx_msg), .rx_accept(rx_accept), .undeliv(undeliv));

  int nchecks = 0, nfail = 0, tx_fire_cnt = 0;
  bit finished = 0;
  logic [MW-1:0] txq0[$], txq1[$], rxq0[$], rxq1[$];

  // layout per R1: pri, dest, src, size, tag, cmd, data
  function automatic logic [MW-1:0] mk(input logic p, input logic [3:0] d,
      input logic [3:0] s, input logic [3:0] sz, input logic [3:0] tg,
      input logic [2:0] cm, input logic [15:0] dt);
    return {p, d, s, sz, tg, cm, dt};
  endfunction
  function automatic logic f_pri(input logic [MW-1:0] m); return m[35]; endfunction
  function automatic logic [3:0] f_dst(input logic [MW-1:0] m); return m[34:31]; endfunction
  function automatic logic [3:0] f_src(input logic [MW-1:0] m); return m[30:27]; endfunction

  task automatic chk(input bit ok, input string req, input logic [MW-1:0] act,
                     input logic [MW-1:0] exp);
    nchecks++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    tx_valid = 0; tx_pri = 0; tx_dest = 0; tx_size = 0; tx_tag = 0;
    tx_cmd = 0; tx_data = 0; rin_valid = 0; rin_msg = '0;
  endtask

  // one clock: inputs already set at the falling edge
  task automatic cycle();
    bit exp_fwd, exp_drop, prev_v, prev_fire, rout_fire, rx_fire, rin_fire, tx_fire;
    logic [MW-1:0] fmsg, dmsg, prev_m, e;
    exp_fwd = 0; exp_drop = 0; fmsg = '0; dmsg = '0;
    #1;
    if (rx_valid && rxq1.size() > 0)
      chk(f_pri(rx_msg) == 1'b1, "R7 high channel first", rx_msg, rxq1[0]);
    if (rxq0.size() == QD) chk(rin_ready[0] == 1'b0, "R8 low stall", MW'(rin_ready), '0);
    if (rxq1.size() == QD) chk(rin_ready[1] == 1'b0, "R8 high stall", MW'(rin_ready), '0);
    rout_fire = rout_valid && rout_ready[f_pri(rout_msg)];
    rx_fire   = rx_valid && rx_accept;
    rin_fire  = rin_valid && rin_ready[f_pri(rin_msg)];
    tx_fire   = tx_valid && tx_ready[tx_pri];
    if (rout_fire && f_src(rout_msg) == 4'(ID)) begin
      if (f_pri(rout_msg)) begin
        e = (txq1.size() > 0) ? txq1[0] : '1;
        chk(txq1.size() > 0 && rout_msg == e, "R1 local high message", rout_msg, e);
        if (txq1.size() > 0) void'(txq1.pop_front());
      end else begin
        e = (txq0.size() > 0) ? txq0[0] : '1;
        chk(txq0.size() > 0 && rout_msg == e, "R1 local low message", rout_msg, e);
        if (txq0.size() > 0) void'(txq0.pop_front());
      end
    end
    if (rx_fire) begin
      if (f_pri(rx_msg)) begin
        e = (rxq1.size() > 0) ? rxq1[0] : '1;
        chk(rxq1.size() > 0 && rx_msg == e, "R7 high receive order", rx_msg, e);
        if (rxq1.size() > 0) void'(rxq1.pop_front());
      end else begin
        e = (rxq0.size() > 0) ? rxq0[0] : '1;
        chk(rxq0.size() > 0 && rx_msg == e, "R7 low receive order", rx_msg, e);
        if (rxq0.size() > 0) void'(rxq0.pop_front());
      end
    end
    if (rin_fire) begin
      if (f_dst(rin_msg) == 4'(ID)) begin
        if (f_pri(rin_msg)) rxq1.push_back(rin_msg); else rxq0.push_back(rin_msg);
      end else if (f_src(rin_msg) == 4'(ID)) begin
        exp_drop = 1; dmsg = rin_msg;
      end else begin
        exp_fwd = 1; fmsg = rin_msg;
      end
    end
    if (tx_fire) begin
      tx_fire_cnt++;
      e = mk(tx_pri, tx_dest, 4'(ID), tx_size, tx_tag, tx_cmd, tx_data);
      if (tx_pri) txq1.push_back(e); else txq0.push_back(e);
    end
    prev_v = rout_valid; prev_m = rout_msg; prev_fire = rout_fire;
    @(posedge clk);
    @(negedge clk);
    if (exp_fwd)
      chk(rout_valid && rout_msg == fmsg, "R3 forward next cycle", rout_msg, fmsg);
    chk(undeliv == exp_drop, "R9 undeliverable flag", MW'(undeliv), MW'(exp_drop));
    if (exp_drop)
      chk(!(rout_valid && rout_msg == dmsg), "R9 dropped not forwarded", rout_msg, dmsg);
    if (prev_v && !prev_fire)
      chk(rout_valid && rout_msg == prev_m, "R6 output held", rout_msg, prev_m);
  endtask

  task automatic send_tx(input logic p, input logic [3:0] d, input logic [15:0] dt);
    tx_valid = 1; tx_pri = p; tx_dest = d; tx_size = 4'h3; tx_tag = dt[3:0];
    tx_cmd = dt[6:4]; tx_data = dt;
    cycle();
    tx_valid = 0;
  endtask

  task automatic drain(input int n);
    idle_inputs(); rout_ready = 2'b11; rx_accept = 1;
    for (int i = 0; i < n; i++) cycle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
    end
  end

  initial begin
    logic [MW-1:0] h1, m;
    int cnt;
    void'($urandom(32'h5eed1234));
    idle_inputs(); rout_ready = 2'b11; rx_accept = 0; rst_n = 0;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(rout_valid == 0, "R10 rout_valid", MW'(rout_valid), '0);
    chk(rx_valid == 0, "R10 rx_valid", MW'(rx_valid), '0);
    chk(undeliv == 0, "R10 undeliv", MW'(undeliv), '0);
    chk(tx_ready == 2'b11, "R10 tx_ready", MW'(tx_ready), MW'(2'b11));
    chk(rin_ready == 2'b11, "R10 rin_ready", MW'(rin_ready), MW'(2'b11));
    rst_n = 1;

    // R5: high served before low once output frees
    rout_ready = 2'b00;
    send_tx(0, 4'h2, 16'h1111);
    cycle();
    send_tx(0, 4'h2, 16'h2222);
    send_tx(1, 4'h3, 16'h3333);
    h1 = mk(1, 4'h3, 4'(ID), 4'h3, 4'h3, 3'h3, 16'h3333);
    rout_ready = 2'b11;
    cycle();
    chk(rout_valid && rout_msg == h1, "R5 high injected first", rout_msg, h1);
    drain(6);

    // R2: send queue full with output stalled
    rout_ready = 2'b00; tx_fire_cnt = 0;
    for (int i = 0; i < 8; i++) send_tx(0, 4'h1, 16'(16'h4000 + i));
    chk(tx_fire_cnt == QD + 1, "R2 accepted count", MW'(tx_fire_cnt), MW'(QD + 1));
    #1 chk(tx_ready == 2'b10, "R2 low full high open", MW'(tx_ready), MW'(2'b10));
    drain(12);

    // R4: forwarding beats queued local traffic
    rout_ready = 2'b00;
    send_tx(0, 4'h7, 16'h5555);
    send_tx(0, 4'h7, 16'h6666);
    rout_ready = 2'b11;
    for (int i = 0; i < 3; i++) begin
      rin_valid = 1; rin_msg = mk(i[0], 4'h9, 4'h2, 4'h1, 4'h0, 3'h1, 16'(16'h7000 + i));
      cycle();
    end
    chk(txq0.size() == 1, "R4 local held back", MW'(txq0.size()), MW'(1));
    drain(6);

    // R8: low receive queue full, high still open
    rx_accept = 0;
    for (int i = 0; i < QD; i++) begin
      rin_valid = 1; rin_msg = mk(0, 4'(ID), 4'h1, 4'h2, 4'h0, 3'h0, 16'(16'h8000 + i));
      cycle();
    end
    rin_msg = mk(0, 4'(ID), 4'h1, 4'h2, 4'h0, 3'h0, 16'h8888);
    #1 chk(rin_ready == 2'b10, "R8 channel stall", MW'(rin_ready), MW'(2'b10));
    cycle();
    chk(rxq0.size() == QD, "R8 nothing extra taken", MW'(rxq0.size()), MW'(QD));
    // R7: high arrives later but is presented first
    rin_msg = mk(1, 4'(ID), 4'h1, 4'h2, 4'h0, 3'h0, 16'h9999);
    cycle();
    rin_valid = 0;
    chk(rx_valid && rx_msg == mk(1, 4'(ID), 4'h1, 4'h2, 4'h0, 3'h0, 16'h9999),
        "R7 high presented", rx_msg, mk(1, 4'(ID), 4'h1, 4'h2, 4'h0, 3'h0, 16'h9999));
    drain(8);

    // R9: own message returns
    rin_valid = 1; rin_msg = mk(1, 4'h3, 4'(ID), 4'h4, 4'hA, 3'h5, 16'hDEAD);
    cycle();
    rin_valid = 0;
    cycle();
    chk(undeliv == 0, "R9 single-cycle flag", MW'(undeliv), '0);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      tx_valid = ($urandom % 3) == 0; tx_pri = $urandom % 2;
      tx_dest = 4'($urandom); tx_size = 4'($urandom); tx_tag = 4'($urandom);
      tx_cmd = 3'($urandom); tx_data = 16'($urandom);
      rin_valid = ($urandom % 2) == 0;
      m = MW'({$urandom, $urandom});
      cnt = $urandom % 8;
      if (cnt < 3) m[34:31] = 4'(ID);
      else if (m[34:31] == 4'(ID)) m[34:31] = 4'(ID + 1);
      if (cnt == 7) m[30:27] = 4'(ID);
      else if (m[30:27] == 4'(ID)) m[30:27] = 4'(ID + 2);
      rin_msg = m;
      rout_ready = 2'($urandom);
      rx_accept = ($urandom % 3) != 0;
      cycle();
    end
    drain(40);
    chk(txq0.size() + txq1.size() == 0, "R1 all local sent",
        MW'(txq0.size() + txq1.size()), '0);
    chk(rxq0.size() + rxq1.size() == 0, "R7 all received",
        MW'(rxq0.size() + rxq1.size()), '0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end
endmodule